// File: doc/BRIEF.md
# Integer ALU with Status Flags and Branch Condition Check

This block is the arithmetic core of a small load/store processor's execute stage. From two operands and a three-bit operation select it produces, in the same cycle, a result word and the next value of the four-bit status word: negative, zero, carry and overflow. Only the arithmetic operations (add, subtract, compare) produce new status bits. Every other operation passes the stored status through unchanged. A write-enable for the status register and a write-enable for the destination register come out with the result. The core that surrounds this block holds the status register and gates it with these enables.

A second, independent path evaluates a three-bit branch condition against the stored status bits and drives a taken signal. The signed orderings are built from negative, overflow and zero. The block has no clock and no state. Because each operand pair produces exactly one answer in the same cycle, nothing is ever held back, so no valid/ready handshake is needed. Control and status pins are plain levels.

Top module: `alu_nzcv_unit`

## Requirements
- R1: Select 0 gives result = op_a + op_b and select 1 gives result = op_a - op_b, both modulo 2^32.
- R2: Select 2 gives bitwise AND, select 3 gives bitwise OR and select 4 gives bitwise XOR of op_a and op_b.
- R3: Select 5 shifts op_a left and select 6 shifts op_a right logically (zero fill), in both cases by op_b[4:0] only. Bits 31..5 of op_b have no effect, so a shift by 32 acts as a shift by 0.
- R4: The status word is laid out as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. For selects 0, 1 and 7, Z is 1 exactly when the 32-bit difference or sum is zero, and N equals its bit 31.
- R5: For add, C is 1 when the unsigned sum wraps, i.e. the truncated sum is below op_a.
- R6: For add, V is 1 when op_a and op_b have equal sign bits and the sum's sign bit differs from them.
- R7: For subtract and compare, C is 1 when no borrow occurs (op_a >= op_b unsigned). V is 1 when the operands differ in sign and the difference's sign differs from op_a.
- R8: Select 7 (compare) forms op_a - op_b for the status bits only: rd_we is 0 and its status bits equal those of a subtract. rd_we is 1 for every other select.
- R9: flags_we is 1 only for selects 0, 1 and 7. For selects 2 to 6, flags_out equals flags_in exactly.
- R10: taken is computed from flags_in and cond_sel. Code 0 is taken when Z=1, code 1 when Z=0, code 2 when N!=V, code 3 when N==V, code 4 when Z=1 or N!=V, and code 5 when Z=0 and N==V. Codes 6 and 7 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; low five bits are the shift amount |
| alu_sel | input | 3 | Operation select (encoding in R1 to R3 and R8) |
| flags_in | input | 4 | Stored status word {N,Z,C,V} |
| cond_sel | input | 3 | Branch condition code (encoding in R10) |
| result | output | 32 | Operation result; the difference for compare |
| flags_out | output | 4 | Next status word {N,Z,C,V} |
| flags_we | output | 1 | High when the operation updates the status word |
| rd_we | output | 1 | High when the result should be written to a register |
| taken | output | 1 | Branch condition satisfied by flags_in |

## Verification
Immediate assertions inside the design run on every evaluation. They check that Z and N follow the driven result whenever status is written, that the add carry agrees with an unsigned comparison of the result against op_a, that non-arithmetic selects leave the status word untouched, that compare never requests a register write, and that the reserved condition codes never report taken. The exact carry and overflow values at the signed and unsigned boundaries are shown only by the bench, as are shift-amount wrapping and the full condition table across all sixteen status words. The bench checks these against its own reference model under directed corner operands and seeded random operands.

// File: rtl/alu_nzcv_pkg.sv
package alu_nzcv_pkg;

  typedef enum logic [2:0] {
    SEL_ADD = 3'd0,
    SEL_SUB = 3'd1,
    SEL_AND = 3'd2,
    SEL_OR  = 3'd3,
    SEL_XOR = 3'd4,
    SEL_SHL = 3'd5,
    SEL_SHR = 3'd6,
    SEL_CMP = 3'd7
  } alu_sel_e;

  typedef enum logic [2:0] {
    CND_EQ   = 3'd0,
    CND_NE   = 3'd1,
    CND_LT   = 3'd2,
    CND_GE   = 3'd3,
    CND_LE   = 3'd4,
    CND_GT   = 3'd5,
    CND_RSV6 = 3'd6,
    CND_RSV7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } status_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = do_sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
    sum   = wide[W-1:0];
    carry = wide[W];
    ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end

  // subtract carry means no borrow: must agree with unsigned compare
  always_comb begin
    if (do_sub) begin
      AST_SUB_NO_BORROW: assert (carry == (a >= b)); // R7
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W = 32
) (
  input  logic [W-1:0]         val,
  input  logic [$clog2(W)-1:0] amt,
  input  logic                 go_right,
  output logic [W-1:0]         shl,
  output logic [W-1:0]         shr
);
  localparam int STG = $clog2(W);

  logic [W-1:0] lstage [0:STG];
  logic [W-1:0] rstage [0:STG];

  assign lstage[0] = val;
  assign rstage[0] = val;

  for (genvar s = 0; s < STG; s++) begin : g_stage
    assign lstage[s+1] = amt[s] ? (lstage[s] << (1 << s)) : lstage[s];
    assign rstage[s+1] = amt[s] ? (rstage[s] >> (1 << s)) : rstage[s];
  end

  assign shl = lstage[STG];
  assign shr = rstage[STG];

  // a right shift by a nonzero amount always clears the top bit
  always_comb begin
    if (go_right && amt != '0) begin
      AST_SHR_ZERO_FILL: assert (shr[W-1] == 1'b0); // R3
    end
  end
endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
  import alu_nzcv_pkg::*;
(
  input  status_t    st,
  input  logic [2:0] code,
  output logic       hit
);
  logic sgn_lt;

  always_comb begin
    sgn_lt = st.n ^ st.v;
    unique case (cond_e'(code))
      CND_EQ:  hit = st.z;
      CND_NE:  hit = ~st.z;
      CND_LT:  hit = sgn_lt;
      CND_GE:  hit = ~sgn_lt;
      CND_LE:  hit = st.z | sgn_lt;
      CND_GT:  hit = ~st.z & ~sgn_lt;
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    AST_RSV_NEVER_TAKEN: assert (!(hit && code[2] && code[1])); // R10
  end
endmodule

// File: rtl/alu_nzcv_unit.sv
module alu_nzcv_unit
  import alu_nzcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        alu_sel,
  input  logic [3:0]        flags_in,
  input  logic [2:0]        cond_sel,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_out,
  output logic              flags_we,
  output logic              rd_we,
  output logic              taken
);
  localparam int SHAMT_W = $clog2(DATA_W);

  alu_sel_e sel;
  logic [DATA_W-1:0] as_sum, sh_l, sh_r;
  logic as_c, as_v, is_sub, is_arith;
  status_t fresh, stored;

  assign sel    = alu_sel_e'(alu_sel);
  assign is_sub = (sel == SEL_SUB) || (sel == SEL_CMP);
  assign stored = status_t'(flags_in);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a(op_a), .b(op_b), .do_sub(is_sub),
    .sum(as_sum), .carry(as_c), .ovf(as_v)
  );

  alu_shifter #(.W(DATA_W)) u_shift (
    .val(op_a), .amt(op_b[SHAMT_W-1:0]), .go_right(sel == SEL_SHR),
    .shl(sh_l), .shr(sh_r)
  );

  alu_cond_eval u_cond (
    .st(stored), .code(cond_sel), .hit(taken)
  );

  always_comb begin
    unique case (sel)
      SEL_ADD, SEL_SUB, SEL_CMP: result = as_sum;
      SEL_AND: result = op_a & op_b;
      SEL_OR:  result = op_a | op_b;
      SEL_XOR: result = op_a ^ op_b;
      SEL_SHL: result = sh_l;
      SEL_SHR: result = sh_r;
      default: result = as_sum;
    endcase
  end

  always_comb begin
    is_arith = (sel == SEL_ADD) || is_sub;
    fresh.n  = as_sum[DATA_W-1];
    fresh.z  = (as_sum == '0);
    fresh.c  = as_c;
    fresh.v  = as_v;
    flags_we  = is_arith;
    rd_we     = (sel != SEL_CMP);
    flags_out = is_arith ? fresh : flags_in;
  end

  always_comb begin
    if (flags_we) begin
      AST_ZN_FOLLOW_RESULT: assert (flags_out[2] == (result == '0) && flags_out[3] == result[DATA_W-1]); // R4
    end
    if (sel == SEL_ADD) begin
      AST_ADD_WRAP_CARRY: assert (flags_out[1] == (result < op_a)); // R5
    end
    if (!flags_we) begin
      AST_STATUS_HELD: assert (flags_out == flags_in); // R9
    end
    if (sel == SEL_CMP) begin
      AST_CMP_NO_WRITE: assert (!rd_we && flags_we); // R8
    end
  end
endmodule

// File: tb/alu_nzcv_unit_bench.sv
module alu_nzcv_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a, b;
  logic [2:0]  sel, cc;
  logic [3:0]  fin;
  logic [31:0] result;
  logic [3:0]  flags_out;
  logic        flags_we, rd_we, taken;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  alu_nzcv_unit u_alu_nzcv_unit (
    .op_a(a), .op_b(b), .alu_sel(sel), .flags_in(fin), .cond_sel(cc),
    .result(result), .flags_out(flags_out), .flags_we(flags_we),
    .rd_we(rd_we), .taken(taken)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] x, input logic [31:0] y, input logic [2:0] s);
    case (s)
      3'd0: return x + y;
      3'd1, 3'd7: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      3'd5: return x << y[4:0];
      default: return x >> y[4:0];
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(input logic [31:0] x, input logic [31:0] y,
                                           input logic [2:0] s, input logic [3:0] f);
    logic [31:0] r;
    logic c, v;
    r = ref_res(x, y, s);
    if (s == 3'd0) begin
      c = (r < x);
      v = (x[31] == y[31]) && (r[31] != x[31]);
    end else if (s == 3'd1 || s == 3'd7) begin
      c = (x >= y);
      v = (x[31] != y[31]) && (r[31] != x[31]);
    end else begin
      return f;
    end
    return {r[31], (r == 32'd0), c, v};
  endfunction

  function automatic logic ref_taken(input logic [3:0] f, input logic [2:0] c);
    logic n, z, v;
    n = f[3]; z = f[2]; v = f[0];
    case (c)
      3'd0: return z;
      3'd1: return !z;
      3'd2: return n != v;
      3'd3: return n == v;
      3'd4: return z || (n != v);
      3'd5: return !z && (n == v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string res_tag(input logic [2:0] s);
    case (s)
      3'd0, 3'd1: return "R1";
      3'd2, 3'd3, 3'd4: return "R2";
      3'd5, 3'd6: return "R3";
      default: return "R8";
    endcase
  endfunction

  function automatic string flag_tag(input logic [2:0] s);
    case (s)
      3'd0: return "R4 R5 R6";
      3'd1: return "R4 R7";
      3'd7: return "R7 R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [2:0] s,
                       input logic [3:0] f, input logic [2:0] c);
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ewe, erd, et;
    bit          bad;
    @(negedge clk);
    a = x; b = y; sel = s; fin = f; cc = c;
    #1;
    er  = ref_res(x, y, s);
    ef  = ref_flags(x, y, s, f);
    ewe = (s == 3'd0 || s == 3'd1 || s == 3'd7);
    erd = (s != 3'd7);
    et  = ref_taken(f, c);
    bad = 1'b0;
    vectors++;
    if (s != 3'd7 && result !== er) begin
      $display("FAIL %s sel=%0d result got %h expected %h", res_tag(s), s, result, er); bad = 1'b1;
    end
    if (flags_out !== ef) begin
      $display("FAIL %s sel=%0d flags got %b expected %b", flag_tag(s), s, flags_out, ef); bad = 1'b1;
    end
    if (flags_we !== ewe) begin
      $display("FAIL R9 sel=%0d flags_we got %b expected %b", s, flags_we, ewe); bad = 1'b1;
    end
    if (rd_we !== erd) begin
      $display("FAIL R8 sel=%0d rd_we got %b expected %b", s, rd_we, erd); bad = 1'b1;
    end
    if (taken !== et) begin
      $display("FAIL R10 cond=%0d flags=%b taken got %b expected %b", c, f, taken, et); bad = 1'b1;
    end
    if (bad) misses++;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    a = '0; b = '0; sel = '0; fin = '0; cc = '0;
    // all-zero start: add of zeros gives Z only (R4)
    apply(32'd0, 32'd0, 3'd0, 4'b0000, 3'd0);
    // R5 R6: signed overflow without carry, and carry with zero result
    apply(32'h7FFF_FFFF, 32'd1, 3'd0, 4'b0000, 3'd2);
    apply(32'hFFFF_FFFF, 32'd1, 3'd0, 4'b1111, 3'd3);
    apply(32'h8000_0000, 32'h8000_0000, 3'd0, 4'b0000, 3'd4);
    // R7: borrow, no-borrow, signed overflow on subtract
    apply(32'd0, 32'd1, 3'd1, 4'b0000, 3'd5);
    apply(32'h8000_0000, 32'd1, 3'd1, 4'b0000, 3'd0);
    apply(32'd5, 32'd5, 3'd1, 4'b0000, 3'd1);
    // R8: compare equal and compare less
    apply(32'd42, 32'd42, 3'd7, 4'b0000, 3'd0);
    apply(32'hFFFF_FFFE, 32'd3, 3'd7, 4'b0000, 3'd2);
    // R3: shift amount wraps modulo 32; upper bits of op_b ignored
    apply(32'hDEAD_BEEF, 32'd32, 3'd5, 4'b1010, 3'd6);
    apply(32'hDEAD_BEEF, 32'd33, 3'd6, 4'b0101, 3'd7);
    apply(32'h8000_0001, 32'd31, 3'd6, 4'b0000, 3'd0);
    apply(32'h8000_0001, 32'hFFFF_FFE1, 3'd5, 4'b0000, 3'd0);
    // R2 R9: logic ops hold every stored flag pattern
    for (int f = 0; f < 16; f++) begin
      apply(32'hF0F0_00FF, 32'h0FF0_0F0F, 3'(2 + (f % 3)), 4'(f), 3'd0);
    end
    // R10: full condition table over every stored status word
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 8; c++) begin
        apply(32'd1, 32'd2, 3'd2, 4'(f), 3'(c));
      end
    end
    // random mix, with sign-boundary operands weighted in
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (($urandom % 4) == 0) x = {x[31], 31'h7FFF_FFFF} ^ {32{x[0]}};
      if (($urandom % 4) == 0) y = x;
      apply(x, y, 3'($urandom), 4'($urandom), 3'($urandom));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule